// File: doc/BRIEF.md
# Dual Down-Counting Interval Timer

This block holds two independent 32-bit down-counting timers behind one word-addressed register window. The window has a write strobe and a read strobe. Software loads a start value and enables a timer. The timer counts down once per clock. When it expires it sets a raw status flag and then either reloads and runs again, or stops at zero.

Each timer has its own interrupt line. That line is the raw flag gated by an interrupt-enable bit. Software acknowledges the flag by writing a one to it. A background-load register changes the value used at the next reload without disturbing the count in progress. The masked status is not stored: it is formed from the raw flag and the enable bit each time it is read.

Top module: `dual_countdown_timer`

## Requirements
- R1: After a synchronous active-low reset, every register of both timers reads zero and both interrupt lines are low.
- R2: Each timer has six registers at word offsets 0 to 5: 0 current count, 1 load, 2 background load, 3 control, 4 raw status, 5 masked status. Timer 0 uses word addresses 0 to 5. Timer 1 uses word addresses 6 to 11, at the same offsets.
- R3: Control bit 0 is enable, bit 1 is one-shot and bit 2 is interrupt enable. A control write with bit 0 set copies the load register into the counter and starts counting. A control write with bit 0 clear stops the counter, which holds its value.
- R4: While running, the counter drops by one each clock. The cycle in which it holds zero is the expiry cycle, so a periodic timer loaded with L expires every L+1 cycles.
- R5: A load write stores the value. If the timer is enabled, the counter restarts from the new value on the next cycle.
- R6: A background-load write stores the value in both the background-load and the load registers. The running count is left alone, and the new value is used at the next reload.
- R7: On expiry a periodic timer reloads from the load register. A one-shot timer holds zero, and its control register still reads the value written.
- R8: Expiry sets raw status bit 0. Writing 1 to bit 0 clears it and writing 0 has no effect. If an expiry and a clearing write happen in the same cycle, the flag stays set.
- R9: The masked status read and the timer's interrupt line both equal raw bit 0 AND control bit 2.
- R10: Writes to the current-count and masked-status registers are ignored. Addresses 12 and above read zero, and writes to them change nothing.
- R11: The two timers run independently. Activity on one never changes the other's registers or interrupt line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (4) | Word address of the access |
| bus_wr | input | 1 | Write strobe, takes effect at the clock edge |
| bus_rd | input | 1 | Read strobe, selects the read data |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, combinational, zero when no read is active |
| irq | output | N_TIMERS (2) | Per-timer interrupt lines |

## Verification
Read data is combinational from the current state, so a read shows the result of every write committed at earlier edges. A write committed at edge E is first visible in the cycle that starts at E. A timer started at edge E holds L-k in the cycle E+k. At edge E+L+1 its raw flag and interrupt line rise, and a periodic timer reloads at that same edge. The bench issues one bus operation per cycle and queues each expected value against the cycle it is due in. Waits are counted out so that every read lands in the exact cycle computed from these rules. That includes a deliberate collision between a clearing write and an expiry edge.

// File: rtl/dtim_pkg.sv
// Shared definitions for the dual down-counting timer.
// Assumes a word-addressed bus. Offsets are word indices within one timer.
package dtim_pkg;
    localparam int REGS_PER_TIMER = 6;
    localparam int CTRL_W         = 3;
    localparam int CTRL_EN        = 0;
    localparam int CTRL_ONESHOT   = 1;
    localparam int CTRL_IE        = 2;

    typedef enum logic [2:0] {
        OFS_VALUE  = 3'd0,
        OFS_LOAD   = 3'd1,
        OFS_BGLOAD = 3'd2,
        OFS_CTRL   = 3'd3,
        OFS_RAW    = 3'd4,
        OFS_MASKED = 3'd5
    } reg_ofs_e;
endpackage

// File: rtl/dtim_decode.sv
// Address decoder: splits a word address into a timer select and a
// register offset, and flags addresses that lie past the last timer.
// Assumes the timers sit back to back, each REGS_PER_TIMER words wide.
module dtim_decode
    import dtim_pkg::*;
#(
    parameter int N_TIMERS = 2,
    parameter int ADDR_W   = 4,
    localparam int SEL_W   = (N_TIMERS > 1) ? $clog2(N_TIMERS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_range,
    output logic [SEL_W-1:0]  sel,
    output reg_ofs_e          ofs
);
    localparam int WINDOW = N_TIMERS * REGS_PER_TIMER;

    // Purpose: split the word index into timer number and register offset.
    always_comb begin
        int unsigned a;
        a        = 32'(addr);
        in_range = (a < WINDOW);
        sel      = SEL_W'(a / REGS_PER_TIMER);
        ofs      = reg_ofs_e'(3'(a % REGS_PER_TIMER));
        if (!in_range) begin
            sel = '0;
            ofs = OFS_VALUE;
        end
    end
endmodule

// File: rtl/dtim_channel.sv
// One down-counting timer with load, background load, control and raw
// status registers. Writes arrive already decoded for this timer.
// Assumes one decrement per clock and that a bus write overrides the
// counter's own update in the same cycle, except that the raw flag keeps
// an expiry when a clearing write lands in the same cycle.
module dtim_channel
    import dtim_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_ofs_e          ofs,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_value,
    output logic              irq,
    output logic [DATA_W-1:0] count_o,
    output logic [DATA_W-1:0] load_o,
    output logic              raw_o,
    output logic              run_o,
    output logic              oneshot_o,
    output logic              ie_o
);
    logic [DATA_W-1:0] count_q, load_q, bgload_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic              raw_q, halted_q;
    logic              running, expire, ack;

    // Purpose: decide whether the counter moves this cycle and whether it expires.
    always_comb begin
        running = ctrl_q[CTRL_EN] && !halted_q;
        expire  = running && (count_q == '0);
        ack     = wr_en && (ofs == OFS_RAW) && wdata[0];
    end

    // Purpose: counter, reload and one-shot halt, with bus writes taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q  <= '0;
            load_q   <= '0;
            bgload_q <= '0;
            ctrl_q   <= '0;
            halted_q <= 1'b0;
        end else begin
            if (running) begin
                if (count_q != '0) begin
                    count_q <= count_q - 1'b1;
                end else if (ctrl_q[CTRL_ONESHOT]) begin
                    halted_q <= 1'b1;
                end else begin
                    count_q <= load_q;
                end
            end
            if (wr_en) begin
                case (ofs)
                    OFS_CTRL: begin
                        ctrl_q   <= wdata[CTRL_W-1:0];
                        halted_q <= 1'b0;
                        count_q  <= wdata[CTRL_EN] ? load_q : count_q;
                    end
                    OFS_LOAD: begin
                        load_q <= wdata;
                        if (ctrl_q[CTRL_EN]) begin
                            count_q  <= wdata;
                            halted_q <= 1'b0;
                        end
                    end
                    OFS_BGLOAD: begin
                        bgload_q <= wdata;
                        load_q   <= wdata;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Purpose: raw status flag; an expiry wins over a clearing write in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= 1'b0;
        else        raw_q <= (raw_q && !ack) || expire;
    end

    // Purpose: select the addressed register for reads.
    always_comb begin
        rd_value = '0;
        case (ofs)
            OFS_VALUE:  rd_value = count_q;
            OFS_LOAD:   rd_value = load_q;
            OFS_BGLOAD: rd_value = bgload_q;
            OFS_CTRL:   rd_value = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
            OFS_RAW:    rd_value = {{(DATA_W-1){1'b0}}, raw_q};
            OFS_MASKED: rd_value = {{(DATA_W-1){1'b0}}, raw_q & ctrl_q[CTRL_IE]};
            default:    rd_value = '0;
        endcase
    end

    // Purpose: interrupt line and observation outputs.
    always_comb begin
        irq       = raw_q && ctrl_q[CTRL_IE];
        count_o   = count_q;
        load_o    = load_q;
        raw_o     = raw_q;
        run_o     = running;
        oneshot_o = ctrl_q[CTRL_ONESHOT];
        ie_o      = ctrl_q[CTRL_IE];
    end
endmodule

// File: rtl/dual_countdown_timer.sv
// Top level: N_TIMERS down-counting timers behind one word-addressed window.
// Assumes single-cycle write strobes and a combinational read path.
module dual_countdown_timer
    import dtim_pkg::*;
#(
    parameter int N_TIMERS = 2,
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [N_TIMERS-1:0] irq
);
    localparam int SEL_W = (N_TIMERS > 1) ? $clog2(N_TIMERS) : 1;

    logic              in_range;
    logic [SEL_W-1:0]  sel;
    reg_ofs_e          ofs;
    logic [DATA_W-1:0] ch_rd    [N_TIMERS];
    logic [DATA_W-1:0] ch_count [N_TIMERS];
    logic [DATA_W-1:0] ch_load  [N_TIMERS];
    logic [N_TIMERS-1:0] ch_raw, ch_run, ch_oneshot, ch_ie;

    dtim_decode #(.N_TIMERS(N_TIMERS), .ADDR_W(ADDR_W)) u_dec (
        .addr(bus_addr), .in_range(in_range), .sel(sel), .ofs(ofs)
    );

    for (genvar i = 0; i < N_TIMERS; i++) begin : g_ch
        logic wr_here;
        assign wr_here = bus_wr && in_range && (32'(sel) == i);
        dtim_channel #(.DATA_W(DATA_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .wr_en(wr_here), .ofs(ofs),
            .wdata(bus_wdata), .rd_value(ch_rd[i]), .irq(irq[i]),
            .count_o(ch_count[i]), .load_o(ch_load[i]), .raw_o(ch_raw[i]),
            .run_o(ch_run[i]), .oneshot_o(ch_oneshot[i]), .ie_o(ch_ie[i])
        );
    end

    // Purpose: return the addressed timer's register, or zero outside the window.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < N_TIMERS; i++) begin
            if (bus_rd && in_range && (32'(sel) == i)) bus_rdata = ch_rd[i];
        end
    end
endmodule

// File: rtl/dtim_checker.sv
// Assertion checker for dual_countdown_timer, attached by bind.
module dtim_checker
    import dtim_pkg::*;
#(
    parameter int N_TIMERS = 2,
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_wr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [N_TIMERS-1:0] irq,
    input logic [DATA_W-1:0]   ch_count [N_TIMERS],
    input logic [DATA_W-1:0]   ch_load  [N_TIMERS],
    input logic [N_TIMERS-1:0] ch_raw,
    input logic [N_TIMERS-1:0] ch_run,
    input logic [N_TIMERS-1:0] ch_oneshot,
    input logic [N_TIMERS-1:0] ch_ie
);
    // R1: lines are quiet in the cycle after a reset edge
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (irq == '0) && (ch_raw == '0));

    for (genvar i = 0; i < N_TIMERS; i++) begin : g_t
        logic touched, ack_wr;
        assign touched = bus_wr && (32'(bus_addr) / REGS_PER_TIMER == i)
                         && (32'(bus_addr) < N_TIMERS * REGS_PER_TIMER);
        assign ack_wr  = touched && (32'(bus_addr) % REGS_PER_TIMER == 32'(OFS_RAW))
                         && bus_wdata[0];

        p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ch_run[i] && (ch_count[i] != '0) && !touched
            |=> ch_count[i] == $past(ch_count[i]) - 1'b1);

        p_periodic_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ch_run[i] && (ch_count[i] == '0) && !ch_oneshot[i] && !touched
            |=> (ch_count[i] == $past(ch_load[i])) && ch_raw[i]);

        p_oneshot_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ch_run[i] && (ch_count[i] == '0) && ch_oneshot[i] && !touched
            |=> (ch_count[i] == '0) && !ch_run[i] && ch_raw[i]);

        p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ack_wr && !(ch_run[i] && (ch_count[i] == '0)) |=> !ch_raw[i]);

        p_irq_needs_raw_r9: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> ch_raw[i] && ch_ie[i]);
    end
endmodule

bind dual_countdown_timer dtim_checker #(
    .N_TIMERS(N_TIMERS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .irq(irq), .ch_count(ch_count), .ch_load(ch_load),
    .ch_raw(ch_raw), .ch_run(ch_run), .ch_oneshot(ch_oneshot), .ch_ie(ch_ie)
);

// File: tb/dual_countdown_timer_test.sv
// Scoreboard bench: driver tasks queue expected values; a monitor compares them.
module dual_countdown_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;
    logic        irq_chk = 1'b0;
    bit          done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];
    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    dual_countdown_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic step();
        @(posedge clk); #2;
        bus_wr = 1'b0; bus_rd = 1'b0; irq_chk = 1'b0;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        step(); bus_addr = 4'(a); bus_wdata = d; bus_wr = 1'b1;
    endtask

    task automatic rd(input int a, input logic [31:0] e, input string tag);
        step(); bus_addr = 4'(a); bus_rd = 1'b1;
        sb.push_back('{e, tag});
    endtask

    task automatic chk_irq(input logic [1:0] e, input string tag);
        step(); irq_chk = 1'b1;
        sb.push_back('{{30'd0, e}, tag});
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    // Monitor: compare mid-cycle, away from the clock edge.
    always @(negedge clk) begin
        if (bus_rd || irq_chk) begin
            item_t it;
            logic [31:0] act;
            act = bus_rd ? bus_rdata : {30'd0, irq};
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard underflow act=%h exp=none", act);
            end else begin
                it = sb.pop_front();
                n_tests++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s act=%h exp=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1 reset state, R10 out-of-range reads
        for (int a = 0; a < 16; a++) rd(a, 0, "R1 reset/R10 range read");
        chk_irq(2'b00, "R1 irq after reset");

        // R3/R4 periodic timer 0, load 5, enable + interrupt enable
        wr(1, 5);
        wr(3, 5);
        rd(0, 5, "R3 start copies load");
        rd(0, 4, "R4 decrement");
        rd(4, 0, "R4 no early expiry");
        idle(3);
        rd(4, 1, "R8 expiry sets raw");
        rd(0, 4, "R7 periodic reload");
        chk_irq(2'b01, "R9 irq raised");
        rd(5, 1, "R9 masked read");

        // R9 masking with interrupt enable off; R8 ack rules
        wr(3, 1);
        rd(5, 0, "R9 masked off");
        chk_irq(2'b00, "R9 irq masked");
        rd(4, 1, "R9 raw kept");
        wr(4, 1);
        rd(4, 0, "R8 write one clears");
        wr(4, 1);
        rd(4, 1, "R8 expiry wins over ack");
        wr(4, 0);
        rd(4, 1, "R8 write zero ignored");
        wr(3, 0);
        rd(0, 2, "R3 disable holds count");
        rd(0, 2, "R3 stopped");

        // R5 load restart, R6 background load
        wr(4, 1);
        wr(3, 1);
        wr(1, 20);
        rd(0, 20, "R5 load restarts count");
        rd(1, 20, "R5 load stored");
        wr(2, 3);
        rd(0, 17, "R6 count undisturbed");
        rd(2, 3, "R6 bgload stored");
        rd(1, 3, "R6 load mirrored");
        idle(15);
        rd(0, 3, "R6 reload uses new value");
        rd(4, 1, "R8 raw after expiry");
        wr(3, 0);
        wr(4, 1);

        // R7 one-shot
        wr(1, 2);
        wr(3, 3);
        idle(3);
        rd(4, 1, "R7 one-shot expiry");
        rd(0, 0, "R7 one-shot at zero");
        idle(2);
        rd(0, 0, "R7 one-shot holds");
        rd(3, 3, "R7 enable left set");

        // R2/R11 timer 1 at word 6
        wr(7, 4);
        wr(9, 5);
        rd(6, 4, "R2 timer1 count");
        rd(0, 0, "R11 timer0 untouched");
        rd(10, 0, "R11 timer1 raw clear");
        idle(2);
        rd(10, 1, "R11 timer1 expiry");
        chk_irq(2'b10, "R11 only irq1");
        rd(11, 1, "R9 timer1 masked");
        rd(3, 3, "R11 timer0 ctrl kept");
        rd(9, 5, "R2 timer1 ctrl");

        // R10 read-only and out-of-range writes
        wr(0, 32'h1234);
        rd(0, 0, "R10 count write ignored");
        wr(5, 1);
        rd(4, 1, "R10 masked write ignored");
        wr(13, 32'hFF);
        rd(13, 0, "R10 out-of-range read");
        rd(12, 0, "R10 out-of-range read");
        rd(1, 2, "R10 timer0 load kept");
        rd(7, 4, "R10 timer1 load kept");

        step();
        @(negedge clk);
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard leftover act=%0d exp=0", sb.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule